// File: doc/BRIEF.md
# I2C Addressed Slave Receiver

This block is a bus slave that listens on the two I2C lines and receives bytes written to it by a bus master. It synchronises SCL and SDA into the system clock, finds START and STOP conditions, and shifts in the first byte after each START as a 7-bit address followed by the direction bit. When that byte names this slave's programmed address, or the all-zero general-call address with general call enabled, and the direction is write, the slave pulls SDA low in the ninth clock. It then takes in data bytes. Slave transmit and 10-bit addressing are not supported.

Software sees three registers on a simple synchronous register port. After the address phase and after every data byte, a completion flag is set. While that flag is set the slave holds SCL low. The master therefore stalls until software has read the byte and cleared the flag. Whether the slave acknowledges is set by a software-owned enable bit, which is sampled at each acknowledge slot.

The open-drain pins are modelled as pull-low enables: `scl_oe`/`sda_oe` at 1 mean the line is driven low. At 0 the line is released.

Top module: `i2c_addr_slave_rx`

## Requirements
- R1: After reset `sda_oe` and `scl_oe` are 0, and the control, own-address and data registers all read 0.
- R2: Register index 0 is control: bit 0 enables the slave, bit 1 enables acknowledge, and bit 7 is the done flag. Writing 1 to bit 7 clears the flag and writing 0 leaves it unchanged. Index 1 is the own address: bits 7:1 hold the 7-bit address and bit 0 enables general call. Index 2 is the read-only received-data register. `reg_rdata` returns the register at `reg_addr` one clock later.
- R3: After a START, the first byte is shifted in MSB first on rising SCL. Bits 7:1 are the address and bit 0 is the direction, with 0 meaning write. The slave acknowledges the byte by pulling SDA low during the ninth clock when all of the following hold: the slave is enabled, acknowledge enable is 1, the direction is write, and either the address equals a nonzero own address or the byte is 0x00 with general call enabled.
- R4: The slave gives no acknowledge and sets no done flag in any of these cases: the direction is read, the address does not match, the own address is zero and general call is off, acknowledge enable is 0, or the slave is disabled. It then ignores the bus until the next START.
- R5: The done flag is set at the falling SCL edge that ends the address acknowledge clock.
- R6: After a data byte, the done flag is set at the end of that byte's ninth clock, and the data register takes the byte. The slave acknowledges the byte only if acknowledge enable is 1 at that moment. After a refused byte the slave ignores further bytes until the next START.
- R7: While the done flag is 1, the slave holds SCL low (`scl_oe` = 1). It releases SCL once the flag is cleared.
- R8: A STOP, or a repeated START, ends the transfer without setting the done flag and without changing the data register. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (2) | Register index |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data, one clock after `reg_addr` |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when forming START and STOP. It holds every SCL phase for several system clocks longer than the three-cycle synchroniser and edge-detection delay. They also assume software does not disable the slave in the middle of an acknowledge slot. The bench master keeps to these limits: it holds each SCL phase for ten clocks, sets SDA only in the low phase, and waits for SCL to read high after releasing it, so stretching is respected. All register writes happen while the slave is idle or stalled.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 2;
  localparam int IDX_CTRL = 0;
  localparam int IDX_OWN  = 1;
  localparam int IDX_DATA = 2;
  // control register bit positions (software visible)
  localparam int CTL_EN   = 0;
  localparam int CTL_ACK  = 1;
  localparam int CTL_DONE = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK
  } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '1;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else begin
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      start_p  <= scl_s && scl_d && sda_d && !sda_s;
      stop_p   <= scl_s && scl_d && !sda_d && sda_s;
      scl_rise <= scl_s && !scl_d;
      scl_fall <= !scl_s && scl_d;
    end
  end
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_slv_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ack_en,
  input  logic          gc_en,
  input  logic [DW-2:0] own_addr,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  output logic          sda_oe,
  output logic          addr_evt,
  output logic          data_evt,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] CNT_BYTE = CW'(DW);
  localparam logic [CW-1:0] CNT_ACK  = CW'(DW + 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          own_hit, gc_hit, addr_ok;

  always_comb begin
    own_hit = (sh[DW-1:1] == own_addr) && (own_addr != '0);
    gc_hit  = (sh[DW-1:1] == '0) && gc_en;
    addr_ok = ack_en && !sh[0] && (own_hit || gc_hit);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_oe   <= 1'b0;
      addr_evt <= 1'b0;
      data_evt <= 1'b0;
      rx_byte  <= '0;
    end else begin
      addr_evt <= 1'b0;
      data_evt <= 1'b0;
      if (start_p) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && cnt < CNT_BYTE) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_BYTE) begin
              if (state == ST_ADDR) begin
                sda_oe <= addr_ok;
                state  <= addr_ok ? ST_ADDR_ACK : ST_IDLE;
              end else begin
                rx_byte <= sh;
                sda_oe  <= ack_en;
                state   <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_rise) begin
              cnt <= CNT_ACK;
            end else if (scl_fall && cnt == CNT_ACK) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (state == ST_ADDR_ACK) begin
                addr_evt <= 1'b1;
                state    <= ST_DATA;
              end else begin
                data_evt <= 1'b1;
                state    <= sda_oe ? ST_DATA : ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
  import i2c_slv_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          addr_evt,
  input  logic          data_evt,
  input  logic [DW-1:0] rx_byte,
  output logic          en_q,
  output logic          ack_en_q,
  output logic          gc_en_q,
  output logic [DW-2:0] own_q,
  output logic          done_q
);
  logic [DW-1:0] data_q;
  logic [DW-1:0] ctrl_view;
  logic          wr_ctrl, wr_own;

  always_comb begin
    wr_ctrl   = reg_wr && (reg_addr == AW'(IDX_CTRL));
    wr_own    = reg_wr && (reg_addr == AW'(IDX_OWN));
    ctrl_view = '0;
    ctrl_view[CTL_EN]   = en_q;
    ctrl_view[CTL_ACK]  = ack_en_q;
    ctrl_view[CTL_DONE] = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ack_en_q <= 1'b0;
      gc_en_q  <= 1'b0;
      own_q    <= '0;
      done_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= reg_wdata[CTL_EN];
        ack_en_q <= reg_wdata[CTL_ACK];
        if (reg_wdata[CTL_DONE]) done_q <= 1'b0;
      end
      if (wr_own) begin
        own_q   <= reg_wdata[DW-1:1];
        gc_en_q <= reg_wdata[0];
      end
      if (addr_evt || data_evt) done_q <= 1'b1;
      if (data_evt) data_q <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        AW'(IDX_CTRL): reg_rdata <= ctrl_view;
        AW'(IDX_OWN):  reg_rdata <= {own_q, gc_en_q};
        AW'(IDX_DATA): reg_rdata <= data_q;
        default:       reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_slave_rx.sv
module i2c_addr_slave_rx
  import i2c_slv_pkg::*;
#(
  parameter int AW          = REG_AW,
  parameter int DW          = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  logic [1:0]    lines_s;
  logic          start_p, stop_p, scl_rise, scl_fall;
  logic          en_q, ack_en_q, gc_en_q, done_q;
  logic [DW-2:0] own_q;
  logic          addr_evt, data_evt;
  logic [DW-1:0] rx_byte;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );

  i2c_bus_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_rx_fsm #(.DW(DW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .ack_en   (ack_en_q),
    .gc_en    (gc_en_q),
    .own_addr (own_q),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (lines_s[0]),
    .sda_oe   (sda_oe),
    .addr_evt (addr_evt),
    .data_evt (data_evt),
    .rx_byte  (rx_byte)
  );

  i2c_slv_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .addr_evt  (addr_evt),
    .data_evt  (data_evt),
    .rx_byte   (rx_byte),
    .en_q      (en_q),
    .ack_en_q  (ack_en_q),
    .gc_en_q   (gc_en_q),
    .own_q     (own_q),
    .done_q    (done_q)
  );

  // the done flag register drives the clock-stretch pull-down directly
  assign scl_oe = done_q;
endmodule

// File: rtl/i2c_slv_rx_chk.sv
module i2c_slv_rx_chk
  import i2c_slv_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = BYTE_W
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          done,
  input logic          en,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata
);
  // R1: lines released in the first cycle after reset
  p_released_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !scl_oe));

  // R2: done only falls after a write of 1 to its control bit
  p_done_clear_by_w1_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(reg_wr && reg_addr == AW'(IDX_CTRL) && reg_wdata[CTL_DONE]));

  // R3: the acknowledge pull-down changes only while SCL is low
  p_sda_moves_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R4: a disabled slave never drives SDA
  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);

  // R7: stretching begins only on a low SCL line
  p_stretch_from_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !$past(scl_i));

  // R5: SDA is released before the stall starts
  p_no_ack_during_stall_r5: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !sda_oe);
endmodule

bind i2c_addr_slave_rx i2c_slv_rx_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .done      (done_q),
  .en        (en_q),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/test_i2c_addr_slave_rx.sv
module test_i2c_addr_slave_rx;
  localparam time CLK_PERIOD = 10ns;
  localparam int  H          = 10;      // clocks per SCL phase
  localparam int  WD_LIMIT   = 150000;
  localparam logic [1:0] I_CTRL = 2'd0, I_OWN = 2'd1, I_DATA = 2'd2;

  // {own[31:24], addr byte[23:16], data[15:8], 6'b0, ack_en, expect_ack}
  localparam logic [31:0] VEC [8] = '{
    32'h9090F503,  // own 0x48 write        -> ack
    32'h90920002,  // other address         -> nack
    32'h90910002,  // own address, read     -> nack
    32'h91003C03,  // general call enabled  -> ack
    32'h90000002,  // general call disabled -> nack
    32'h00000002,  // own address zero      -> nack
    32'hFEFE8103,  // own 0x7F              -> ack
    32'h90900000   // ack enable off        -> nack
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe;
  wire  scl_bus = scl_m & ~scl_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int   total = 0, bad = 0, cyc = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_slave_rx i_i2c_addr_slave_rx (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic m_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic m_bit(input logic b, output logic s);
    sda_m = b; wait_clk(H);
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    wait_clk(H);
    s = sda_bus;
    scl_m = 1'b0; wait_clk(H);
  endtask

  // returns 1 when the slave acknowledged
  task automatic m_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(v[i], s);
    m_bit(1'b1, s);
    acked = ~s;
  endtask

  initial begin
    logic       ak;
    logic [7:0] r;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    rd(I_CTRL, r); chk("R1 ctrl", r, 8'h00);
    rd(I_OWN, r);  chk("R1 own", r, 8'h00);
    rd(I_DATA, r); chk("R1 data", r, 8'h00);

    // table of address-phase cases
    foreach (VEC[k]) begin
      logic [31:0] v;
      v = VEC[k];
      wr(I_OWN, v[31:24]);
      wr(I_CTRL, {6'b0, v[1], 1'b1});
      rd(I_OWN, r); chk("R2 own readback", r, v[31:24]);
      m_start();
      m_byte(v[23:16], ak);
      chk(v[0] ? "R3 address ack" : "R4 address nack", ak, v[0]);
      wait_clk(6);
      rd(I_CTRL, r);
      if (v[0]) begin
        chk("R5 done after address", r[7], 1);
        chk("R7 stretch while done", scl_oe, 1);
        wr(I_CTRL, 8'h83);
        wait_clk(2);
        chk("R7 release after clear", scl_oe, 0);
        m_byte(v[15:8], ak);
        chk("R6 data ack", ak, 1);
        wait_clk(6);
        rd(I_CTRL, r); chk("R6 done after data", r[7], 1);
        rd(I_DATA, r); chk("R6 data value", r, v[15:8]);
        wr(I_CTRL, 8'h83);
      end else begin
        chk("R4 no done on miss", r[7], 0);
      end
      m_stop();
      wait_clk(H);
    end

    // write 0 keeps done, stretch holds, STOP returns to idle
    wr(I_OWN, 8'h90); wr(I_CTRL, 8'h03);
    m_start(); m_byte(8'h90, ak); chk("R3 address ack", ak, 1);
    wait_clk(6);
    wr(I_CTRL, 8'h03);
    rd(I_CTRL, r); chk("R2 write 0 keeps done", r[7], 1);
    sda_m = 1'b0; wait_clk(2);
    scl_m = 1'b1; wait_clk(40);
    chk("R7 SCL held low", scl_bus, 0);
    wr(I_CTRL, 8'h83); wait_clk(6);
    chk("R7 SCL released", scl_bus, 1);
    wait_clk(H); sda_m = 1'b1; wait_clk(H);
    rd(I_CTRL, r); chk("R8 STOP sets no done", r[7], 0);
    m_byte(8'h90, ak); chk("R8 idle after STOP ignores byte", ak, 0);
    m_stop(); wait_clk(H);

    // multi-byte, then repeated START to a miss and to a hit
    m_start(); m_byte(8'h90, ak); wait_clk(6); wr(I_CTRL, 8'h83);
    m_byte(8'h11, ak); wait_clk(6); wr(I_CTRL, 8'h83);
    m_byte(8'h22, ak); chk("R6 second byte ack", ak, 1);
    wait_clk(6);
    rd(I_DATA, r); chk("R6 last byte kept", r, 8'h22);
    wr(I_CTRL, 8'h83);
    m_start(); m_byte(8'h92, ak); chk("R8 repeated START miss nack", ak, 0);
    wait_clk(6);
    rd(I_CTRL, r); chk("R8 no done on repeated START", r[7], 0);
    rd(I_DATA, r); chk("R8 data unchanged", r, 8'h22);
    m_start(); m_byte(8'h90, ak); chk("R8 repeated START new address", ak, 1);
    wait_clk(6); wr(I_CTRL, 8'h83);
    m_stop(); wait_clk(H);

    // data byte refused when acknowledge enable is cleared
    m_start(); m_byte(8'h90, ak); wait_clk(6);
    wr(I_CTRL, 8'h81);
    m_byte(8'h5A, ak); chk("R6 data nack", ak, 0);
    wait_clk(6);
    rd(I_CTRL, r); chk("R6 done after refused byte", r[7], 1);
    rd(I_DATA, r); chk("R6 refused byte stored", r, 8'h5A);
    wr(I_CTRL, 8'h83);
    m_byte(8'h66, ak); chk("R6 ignore after nack", ak, 0);
    wait_clk(6);
    rd(I_CTRL, r); chk("R6 no done after nack", r[7], 0);
    m_stop(); wait_clk(H);

    // disabled slave
    wr(I_CTRL, 8'h02);
    m_start(); m_byte(8'h90, ak); chk("R4 disabled nack", ak, 0);
    wait_clk(6);
    rd(I_CTRL, r); chk("R4 disabled no done", r[7], 0);
    m_stop(); wait_clk(H);

    summary();
  end
endmodule